// File: doc/BRIEF.md
# Synchronous Receive CRC Checker

This block checks a 16-bit CRC on the received bit stream of a synchronous serial receiver. Each received bit arrives with a valid strobe. A boundary strobe marks the last bit of every character, whatever its length. A load strobe says whether that character went into the receive buffer or was removed as a sync pattern. Before a bit reaches the CRC register, it passes through an 8-bit delay line. The host therefore has one character time to decide whether the character now in the buffer should count toward the check.

The host selects the polynomial and the preset value, holds a master enable, and can issue a one-cycle command that reloads the preset. It also drives a level that requests inclusion for each character. The block latches that request only at a loaded-character boundary, so coverage always starts and stops on whole characters.

While the receiver reports hunt mode, the register is forced to its preset every cycle. A small gating state machine tracks the span from hunt exit to the first data character. Its states are GATE_HUNT, GATE_WAIT_FIRST and GATE_RUN, with these transitions:
- hunt moves any state to GATE_HUNT.
- GATE_HUNT moves to GATE_WAIT_FIRST on the first cycle without hunt.
- GATE_WAIT_FIRST moves to GATE_RUN at the first boundary whose character was loaded.
- GATE_RUN stays in GATE_RUN until hunt.

Top module: `sync_rx_crc_check`

## Requirements
- R1: `poly_sel`=1 selects CRC-16 (x^16+x^15+x^2+1) and `poly_sel`=0 selects CRC-CCITT (x^16+x^12+x^5+1). Bits are taken least significant first. On each accepted bit, the register shifts right by one. When bit 0 of the register XOR the incoming bit equals 1, the register is then XORed with 0xA001 (CRC-16) or 0x8408 (CCITT).
- R2: The preset value is 0xFFFF when `preset_ones`=1 and 0x0000 when `preset_ones`=0. After `rst_n` the register reads 0x0000.
- R3: In every cycle with `hunt`=1, the register is loaded with the preset and the delay line is cleared to zeros. Accumulation is also switched off.
- R4: A one-cycle `clr_cmd` loads the preset on the next edge, even in a cycle where a bit would otherwise be accumulated.
- R5: While `crc_en`=0, the register holds its value.
- R6: The bit that updates the register is the one that entered 8 valid bits earlier. A bit therefore reaches the register on the 8th valid cycle after its own.
- R7: `incl_req` is sampled only when `char_end`=1 and `char_load`=1. The sampled value gates every bit that leaves the delay line until the next boundary. Changes of `incl_req` between boundaries have no effect.
- R8: A boundary with `char_load`=0 marks a stripped sync character. It switches accumulation off for the bits that follow, whatever `incl_req` is.
- R9: With `strip_on`=0, the first loaded character after hunt is excluded. With `strip_on`=1, the first loaded character uses `incl_req`.
- R10: Characters may be 5 to 8 bits long and may change length from one character to the next. `char_end` marks the last bit of each.
- R11: `crc_ok` is 1 exactly when the register holds 0x0000. This is the residue after a frame followed by its own check value, low byte first.
- R12: Cycles with `bit_valid`=0 change neither the register nor the delay line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_valid | input | 1 | A received bit is present this cycle |
| bit_in | input | 1 | Received bit |
| char_end | input | 1 | This bit is the last of a character |
| char_load | input | 1 | With char_end: the character was loaded into the buffer (0 = stripped) |
| hunt | input | 1 | Receiver is hunting for sync |
| strip_on | input | 1 | Sync stripping is active |
| poly_sel | input | 1 | 1 = CRC-16, 0 = CRC-CCITT |
| preset_ones | input | 1 | 1 = preset all ones, 0 = all zeros |
| crc_en | input | 1 | Master enable for accumulation |
| clr_cmd | input | 1 | One-cycle command that reloads the preset |
| incl_req | input | 1 | Host request to include the character |
| crc_value | output | 16 | Current CRC register |
| crc_ok | output | 1 | Register equals the zero residue |

## Verification
The hardest case to reach is a host decision that lands one character late. The inclusion request must be latched at one boundary and applied to bits of the character before it, which are still in the delay line. To get there, the stimulus sends eight-character messages in which the request changes in the middle of an excluded character. The register is then compared with a bench-computed CRC of only the covered bytes, at the point just after the excluded character has drained. A second sequence mixes character lengths of 5 to 8 bits, so that the delay spans partial characters. The expected value is computed from the zero-prefixed bit stream from the first boundary onward.

// File: rtl/crc_rx_pkg.sv
package crc_rx_pkg;

    typedef enum logic [1:0] {
        GATE_HUNT       = 2'd0,
        GATE_WAIT_FIRST = 2'd1,
        GATE_RUN        = 2'd2
    } gate_state_e;

    localparam int unsigned CRC_WIDTH   = 16;
    localparam int unsigned DELAY_BITS  = 8;
    localparam logic [15:0] POLY16_REV  = 16'hA001;
    localparam logic [15:0] CCITT_REV   = 16'h8408;

endpackage

// File: rtl/crc_bit_step.sv
module crc_bit_step #(
    parameter int unsigned W        = 16,
    parameter logic [W-1:0] MASK_HI = 16'hA001,
    parameter logic [W-1:0] MASK_LO = 16'h8408
) (
    input  logic [W-1:0] crc_in,
    input  logic         din,
    input  logic         sel_hi,
    output logic [W-1:0] crc_out
);
    logic         feedback;
    logic [W-1:0] mask;

    always_comb begin
        feedback = crc_in[0] ^ din;
        mask     = sel_hi ? MASK_HI : MASK_LO;
        crc_out  = (crc_in >> 1) ^ (feedback ? mask : '0);
    end
endmodule

// File: rtl/rx_bit_delay.sv
module rx_bit_delay #(
    parameter int unsigned DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic shift,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (clear) begin
            line_q <= '0;
        end else if (shift) begin
            line_q <= {din, line_q[DEPTH-1:1]};
        end
    end

    assign dout = line_q[0];

    AST_DELAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift && !clear) |=> $stable(line_q)); // R12
    AST_DELAY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (line_q == '0)); // R3
endmodule

// File: rtl/crc_gate_fsm.sv
module crc_gate_fsm
    import crc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hunt,
    input  logic char_end,
    input  logic char_load,
    input  logic strip_on,
    input  logic incl_req,
    output logic gate
);
    gate_state_e state_q, state_d;
    logic        gate_q, gate_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GATE_HUNT;
            gate_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            gate_q  <= gate_d;
        end
    end

    always_comb begin
        state_d = state_q;
        gate_d  = gate_q;
        unique case (state_q)
            GATE_HUNT: begin
                gate_d  = 1'b0;
                state_d = GATE_WAIT_FIRST;
            end
            GATE_WAIT_FIRST: begin
                if (char_end) begin
                    if (!char_load) begin
                        gate_d = 1'b0;
                    end else begin
                        gate_d  = strip_on ? incl_req : 1'b0;
                        state_d = GATE_RUN;
                    end
                end
            end
            GATE_RUN: begin
                if (char_end) begin
                    gate_d = char_load ? incl_req : 1'b0;
                end
            end
            default: begin
                gate_d  = 1'b0;
                state_d = GATE_HUNT;
            end
        endcase
        if (hunt) begin
            state_d = GATE_HUNT;
            gate_d  = 1'b0;
        end
    end

    assign gate = gate_q;

    AST_GATE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (!char_end && !hunt) |=> $stable(gate_q)); // R7
    AST_STRIPPED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (char_end && !char_load) |=> !gate_q); // R8
    AST_HUNT_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        hunt |=> (!gate_q && state_q == GATE_HUNT)); // R3
endmodule

// File: rtl/sync_rx_crc_check.sv
module sync_rx_crc_check
    import crc_rx_pkg::*;
#(
    parameter int unsigned CRC_W    = CRC_WIDTH,
    parameter int unsigned DLY_BITS = DELAY_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic             char_end,
    input  logic             char_load,
    input  logic             hunt,
    input  logic             strip_on,
    input  logic             poly_sel,
    input  logic             preset_ones,
    input  logic             crc_en,
    input  logic             clr_cmd,
    input  logic             incl_req,
    output logic [CRC_W-1:0] crc_value,
    output logic             crc_ok
);
    logic             delayed_bit;
    logic             gate;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_next;
    logic [CRC_W-1:0] preset;
    logic             accept;

    rx_bit_delay #(.DEPTH(DLY_BITS)) i_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (hunt),
        .shift (bit_valid),
        .din   (bit_in),
        .dout  (delayed_bit)
    );

    crc_gate_fsm i_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .hunt      (hunt),
        .char_end  (char_end & bit_valid),
        .char_load (char_load),
        .strip_on  (strip_on),
        .incl_req  (incl_req),
        .gate      (gate)
    );

    crc_bit_step #(
        .W       (CRC_W),
        .MASK_HI (POLY16_REV[CRC_W-1:0]),
        .MASK_LO (CCITT_REV[CRC_W-1:0])
    ) i_step (
        .crc_in  (crc_q),
        .din     (delayed_bit),
        .sel_hi  (poly_sel),
        .crc_out (crc_next)
    );

    assign preset = {CRC_W{preset_ones}};
    assign accept = bit_valid & crc_en & gate;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (hunt || clr_cmd) begin
            crc_q <= preset;
        end else if (accept) begin
            crc_q <= crc_next;
        end
    end

    assign crc_value = crc_q;
    assign crc_ok    = (crc_q == '0);

    AST_HUNT_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        hunt |=> (crc_value == {CRC_W{$past(preset_ones)}})); // R3
    AST_CLR_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> (crc_value == {CRC_W{$past(preset_ones)}})); // R4
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!crc_en && !hunt && !clr_cmd) |=> $stable(crc_value)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_valid && !hunt && !clr_cmd) |=> $stable(crc_value)); // R12
endmodule

// File: tb/test_sync_rx_crc_check.sv
module test_sync_rx_crc_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_valid = 1'b0, bit_in = 1'b0, char_end = 1'b0, char_load = 1'b0;
    logic        hunt = 1'b0, strip_on = 1'b0, poly_sel = 1'b0, preset_ones = 1'b0;
    logic        crc_en = 1'b1, clr_cmd = 1'b0, incl_req = 1'b0;
    logic [15:0] crc_value;
    logic        crc_ok;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sync_rx_crc_check i_sync_rx_crc_check (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .char_end(char_end), .char_load(char_load), .hunt(hunt),
        .strip_on(strip_on), .poly_sel(poly_sel), .preset_ones(preset_ones),
        .crc_en(crc_en), .clr_cmd(clr_cmd), .incl_req(incl_req),
        .crc_value(crc_value), .crc_ok(crc_ok)
    );

    function automatic logic [15:0] step(input logic [15:0] c, input logic b, input logic sel);
        logic [15:0] m;
        m = sel ? 16'hA001 : 16'h8408;
        return (c >> 1) ^ ((c[0] ^ b) ? m : 16'h0000);
    endfunction

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d, input logic sel);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) r = step(r, d[i], sel);
        return r;
    endfunction

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_valid = 1'b0; char_end = 1'b0; char_load = 1'b0; clr_cmd = 1'b0; hunt = 1'b0;
        end
    endtask

    task automatic send_char(input logic [7:0] d, input int len, input logic load,
                             input logic early, input logic late);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            bit_valid = 1'b1;
            bit_in    = d[i];
            char_end  = (i == len - 1);
            char_load = load && (i == len - 1);
            incl_req  = (i < len / 2) ? early : late;
        end
        idle(1);
    endtask

    task automatic do_hunt(input logic sel, input logic pres, input logic strip);
        @(negedge clk);
        poly_sel = sel; preset_ones = pres; strip_on = strip; hunt = 1'b1;
        @(negedge clk);
        hunt = 1'b1;
        idle(1);
    endtask

    task automatic run_msg(input logic sel, input logic pres, input logic [7:0] b,
                           input logic [7:0] c, input logic en);
        logic [15:0] p, r, e;
        p = {16{pres}};
        crc_en = en;
        do_hunt(sel, pres, 1'b0);
        check("R3/R2 hunt preset", {1'b0, crc_value}, {1'b0, p});
        r = crc_byte(crc_byte(p, b, sel), c, sel);
        send_char(8'h7E, 8, 1'b1, 1'b1, 1'b1);   // A: first loaded, excluded (R9)
        send_char(b, 8, 1'b1, 1'b1, 1'b1);       // B included
        send_char(c, 8, 1'b1, 1'b1, 1'b1);       // C included
        send_char(8'h5A, 8, 1'b1, 1'b1, 1'b0);   // D: request toggles mid-char, latched 0
        send_char(r[7:0], 8, 1'b1, 1'b1, 1'b1);  // E
        e = en ? r : p;
        check("R7/R6/R1 partial crc over B,C", {1'b0, crc_value}, {1'b0, e});
        send_char(r[15:8], 8, 1'b1, 1'b1, 1'b1); // F
        send_char(8'hC3, 8, 1'b1, 1'b0, 1'b0);   // G
        e = en ? 16'h0000 : p;
        check("R11 residue after F", {crc_ok, crc_value}, {(e == 16'h0000), e});
        send_char(8'h99, 8, 1'b1, 1'b0, 1'b0);   // H excluded
        check("R7 G excluded", {crc_ok, crc_value}, {(e == 16'h0000), e});
        idle(5);
        check("R12 idle hold", {1'b0, crc_value}, {1'b0, e});
        crc_en = 1'b1;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0]  pb [0:5];
        logic [15:0] e, p;
        int          lens [0:5];
        logic        stream [0:63];
        int          n;
        pb[0] = 8'h00; pb[1] = 8'hFF; pb[2] = 8'h31; pb[3] = 8'hA5; pb[4] = 8'h80; pb[5] = 8'h1C;

        idle(3);
        rst_n = 1'b1;
        idle(1);
        check("R2 reset value", {crc_ok, crc_value}, {1'b1, 16'h0000});

        for (int s = 0; s < 2; s++)
            for (int q = 0; q < 2; q++)
                for (int k = 0; k < 5; k++)
                    run_msg(s[0], q[0], pb[k], pb[k+1], 1'b1);

        run_msg(1'b0, 1'b1, 8'h12, 8'h34, 1'b0); // R5 master enable off

        // R4: reload preset command
        preset_ones = 1'b1;
        @(negedge clk); clr_cmd = 1'b1;
        idle(1);
        check("R4 clr loads ones", {crc_ok, crc_value}, {1'b0, 16'hFFFF});
        preset_ones = 1'b0;
        @(negedge clk); clr_cmd = 1'b1;
        idle(1);
        check("R4 clr loads zeros", {crc_ok, crc_value}, {1'b1, 16'h0000});

        // R8/R9: stripped sync then first data character included
        do_hunt(1'b0, 1'b1, 1'b1);
        send_char(8'h16, 8, 1'b0, 1'b1, 1'b1);   // stripped, request ignored
        send_char(8'h4B, 8, 1'b1, 1'b1, 1'b1);   // first data, strip on: included
        send_char(8'hE2, 8, 1'b1, 1'b1, 1'b1);
        p = crc_byte(16'hFFFF, 8'h4B, 1'b0);
        check("R8/R9 stripped sync excluded", {1'b0, crc_value}, {1'b0, p});
        e = crc_byte(p, 8'hE2, 1'b0);
        send_char(e[7:0], 8, 1'b1, 1'b1, 1'b1);
        send_char(e[15:8], 8, 1'b1, 1'b1, 1'b1);
        send_char(8'h00, 8, 1'b1, 1'b0, 1'b0);
        check("R11/R9 strip residue", {crc_ok, crc_value}, {1'b1, 16'h0000});

        // R10: mixed character lengths, CRC-16, zero preset
        lens[0] = 5; lens[1] = 8; lens[2] = 6; lens[3] = 7; lens[4] = 5; lens[5] = 8;
        for (int i = 0; i < 64; i++) stream[i] = 1'b0;
        n = 8;
        for (int c = 0; c < 6; c++)
            for (int i = 0; i < lens[c]; i++) begin
                stream[n] = pb[c][i] ^ i[0];
                n++;
            end
        do_hunt(1'b1, 1'b0, 1'b1);
        for (int c = 0; c < 6; c++) begin
            logic [7:0] d;
            for (int i = 0; i < 8; i++) d[i] = pb[c][i] ^ i[0];
            send_char(d, lens[c], 1'b1, 1'b1, 1'b1);
        end
        e = 16'h0000;
        for (int k = lens[0]; k < n - 8; k++) e = step(e, stream[k], 1'b1);
        check("R10 mixed lengths", {1'b0, crc_value}, {1'b0, e});

        // R3: hunt mid-stream forces preset
        @(negedge clk); preset_ones = 1'b1; hunt = 1'b1;
        idle(1);
        check("R3 hunt reload", {crc_ok, crc_value}, {1'b0, 16'hFFFF});

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule